// File: doc/BRIEF.md
# Dual-Port Blocking Memory Forwarder

This block connects two requester ports, one for instruction fetches and one for data, to a single memory-side port. It allows one transaction at a time. A request taken from either requester is registered and offered to memory on the next cycle. The memory response goes back to the instruction port when the request's fetch bit was set, and to the data port when it was clear.

Back-pressure uses refuse-and-retry, not ready/valid. Each side offers an item as a one-cycle pulse, and the receiver either takes it in that cycle or refuses it. After a refusal, the sender keeps the item and offers it again only when the receiver pulses a retry strobe. A requester that is refused is owed a retry strobe later, and the block sends that strobe once it can take a request again.

The memory-side controller has four states:
- IDLE: nothing outstanding.
- SEND: the request is offered to memory. Taken goes to WAIT; refused goes to HELD.
- HELD: waits for the memory retry strobe, then goes back to SEND.
- WAIT: waits for the response, then goes to IDLE.

Each requester port has a response holder with three states:
- EMPTY: holds nothing. A response load goes to SEND.
- SEND: the response is offered. Taken goes to EMPTY; refused goes to HELD.
- HELD: waits for the requester's retry strobe, then goes back to SEND.

Top module: `fwd_dual_blocking`

## Requirements
- R1: A request is taken only when the memory-side controller is IDLE and both response holders are EMPTY. In every other cycle, `*_req_acc` stays low even when `*_req_vld` is high.
- R2: A requester port whose valid request is refused records that it is owed a retry. It later receives exactly one `*_retry_req` pulse.
- R3: A request taken in cycle N appears on `mem_req_*` in cycle N+1 with unchanged address, command, size, data and fetch bit. If memory refuses it, the identical request is offered again in the cycle after `mem_retry` is pulsed.
- R4: While a refused memory request is held, `mem_req_vld` stays low until the memory retry strobe is seen.
- R5: A memory response arriving in cycle N is offered in cycle N+1 on the instruction port when the request's fetch bit was 1, and on the data port when it was 0. It carries the request's address and write bit and the memory's read data.
- R6: Receiving the memory response returns the controller to IDLE. A new request can be taken as soon as the delivered response leaves its holder.
- R7: `*_retry_req` is pulsed only when all of these hold: the port is owed a retry, the controller is IDLE, both holders are EMPTY, and no request is taken in that cycle. The pulse clears the owed flag.
- R8: A response refused by a requester is held and not offered again until that requester pulses `*_rsp_retry`. It is then offered unchanged in the next cycle.
- R9: Reset leaves no transaction outstanding, no retry owed and no response held. All valid, accept and retry outputs are low.
- R10: When both requesters are valid in a cycle where a request can be taken, the instruction port is taken and the data port is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ip_req_vld | input | 1 | Instruction requester offers a request |
| ip_req_addr | input | AW | Request address |
| ip_req_wr | input | 1 | 1 = write, 0 = read |
| ip_req_size | input | SW | Access size code |
| ip_req_wdata | input | DW | Write data |
| ip_req_fetch | input | 1 | 1 = instruction fetch |
| ip_req_acc | output | 1 | Request taken this cycle |
| ip_retry_req | output | 1 | Retry strobe to the instruction requester |
| ip_rsp_vld | output | 1 | Response offered |
| ip_rsp_addr | output | AW | Response address |
| ip_rsp_wr | output | 1 | Response command bit |
| ip_rsp_rdata | output | DW | Response data |
| ip_rsp_acc | input | 1 | Requester takes the response |
| ip_rsp_retry | input | 1 | Requester asks for the held response again |
| dp_req_vld | input | 1 | Data requester offers a request |
| dp_req_addr | input | AW | Request address |
| dp_req_wr | input | 1 | 1 = write, 0 = read |
| dp_req_size | input | SW | Access size code |
| dp_req_wdata | input | DW | Write data |
| dp_req_fetch | input | 1 | 1 = instruction fetch |
| dp_req_acc | output | 1 | Request taken this cycle |
| dp_retry_req | output | 1 | Retry strobe to the data requester |
| dp_rsp_vld | output | 1 | Response offered |
| dp_rsp_addr | output | AW | Response address |
| dp_rsp_wr | output | 1 | Response command bit |
| dp_rsp_rdata | output | DW | Response data |
| dp_rsp_acc | input | 1 | Requester takes the response |
| dp_rsp_retry | input | 1 | Requester asks for the held response again |
| mem_req_vld | output | 1 | Request offered to memory |
| mem_req_addr | output | AW | Address |
| mem_req_wr | output | 1 | Command bit |
| mem_req_size | output | SW | Size code |
| mem_req_wdata | output | DW | Write data |
| mem_req_fetch | output | 1 | Fetch bit |
| mem_req_acc | input | 1 | Memory takes the request |
| mem_retry | input | 1 | Memory asks for the held request again |
| mem_rsp_vld | input | 1 | Memory response |
| mem_rsp_rdata | input | DW | Response data |

## Verification
A stuck or wrongly set busy state shows up at a requester's accept output in the cycle it is offered a request: the request is either refused wrongly or taken during a transaction. A lost or spurious owed-retry flag shows up as a missing or extra retry pulse on the first cycle the block becomes free. A corrupted held request or held response shows up in the cycle after the matching retry strobe, when the offered fields differ from what was first presented. A wrong fetch bit moves the response to the other port one cycle after the memory answers.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {MS_IDLE, MS_SEND, MS_HELD, MS_WAIT} mside_e;
    typedef enum logic [1:0] {RS_EMPTY, RS_SEND, RS_HELD} rside_e;
    localparam int NPORT  = 2;
    localparam int PORT_I = 0;
    localparam int PORT_D = 1;
endpackage

// File: rtl/fwd_req_path.sv
module fwd_req_path
    import fwd_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [PW-1:0] take_pkt,
    input  logic          mem_acc,
    input  logic          mem_retry,
    input  logic          mem_rsp_vld,
    output logic [PW-1:0] pkt_q,
    output logic          mem_vld,
    output logic          idle,
    output logic          rsp_take
);
    mside_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    pkt_q <= '0;
        else if (take) pkt_q <= take_pkt;
    end

    always_comb begin
        st_d     = st_q;
        mem_vld  = 1'b0;
        idle     = 1'b0;
        rsp_take = 1'b0;
        unique case (st_q)
            MS_IDLE: begin
                idle = 1'b1;
                if (take) st_d = MS_SEND;
            end
            MS_SEND: begin
                mem_vld = 1'b1;
                st_d    = mem_acc ? MS_WAIT : MS_HELD;
            end
            MS_HELD: begin
                if (mem_retry) st_d = MS_SEND;
            end
            MS_WAIT: begin
                if (mem_rsp_vld) begin
                    rsp_take = 1'b1;
                    st_d     = MS_IDLE;
                end
            end
            default: st_d = MS_IDLE;
        endcase
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != MS_IDLE) |-> !take); // R1
    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_vld && !mem_acc && !mem_retry) |=> !mem_vld); // R4
    AST_HELD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_vld && !mem_acc) |=> $stable(pkt_q)); // R3
    AST_RSP_WHEN_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_vld |-> (st_q == MS_WAIT)); // R6
endmodule

// File: rtl/fwd_port_side.sv
module fwd_port_side
    import fwd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          refused,
    input  logic          retry_ok,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          load_wr,
    input  logic [DW-1:0] load_data,
    input  logic          rsp_acc,
    input  logic          rsp_retry,
    output logic          retry_req,
    output logic          rsp_vld,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_wr,
    output logic [DW-1:0] rsp_data,
    output logic          holding
);
    rside_e st_q, st_d;
    logic   need_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RS_EMPTY;
            need_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (refused)        need_q <= 1'b1;
            else if (retry_req) need_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr <= '0;
            rsp_wr   <= 1'b0;
            rsp_data <= '0;
        end else if (load && st_q == RS_EMPTY) begin
            rsp_addr <= load_addr;
            rsp_wr   <= load_wr;
            rsp_data <= load_data;
        end
    end

    always_comb begin
        st_d      = st_q;
        rsp_vld   = 1'b0;
        holding   = 1'b1;
        retry_req = need_q && retry_ok;
        unique case (st_q)
            RS_EMPTY: begin
                holding = 1'b0;
                if (load) st_d = RS_SEND;
            end
            RS_SEND: begin
                rsp_vld = 1'b1;
                st_d    = rsp_acc ? RS_EMPTY : RS_HELD;
            end
            RS_HELD: begin
                if (rsp_retry) st_d = RS_SEND;
            end
            default: st_d = RS_EMPTY;
        endcase
    end

    AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> !retry_req); // R7
    AST_RETRY_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> (st_q == RS_EMPTY)); // R7
    AST_RSP_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_acc && !rsp_retry) |=> !rsp_vld); // R8
    AST_RSP_HELD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_acc) |=> $stable(rsp_data) && $stable(rsp_addr)); // R8
    AST_NO_LOAD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !holding); // R5
endmodule

// File: rtl/fwd_dual_blocking.sv
module fwd_dual_blocking
    import fwd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ip_req_vld,
    input  logic [AW-1:0] ip_req_addr,
    input  logic          ip_req_wr,
    input  logic [SW-1:0] ip_req_size,
    input  logic [DW-1:0] ip_req_wdata,
    input  logic          ip_req_fetch,
    output logic          ip_req_acc,
    output logic          ip_retry_req,
    output logic          ip_rsp_vld,
    output logic [AW-1:0] ip_rsp_addr,
    output logic          ip_rsp_wr,
    output logic [DW-1:0] ip_rsp_rdata,
    input  logic          ip_rsp_acc,
    input  logic          ip_rsp_retry,
    input  logic          dp_req_vld,
    input  logic [AW-1:0] dp_req_addr,
    input  logic          dp_req_wr,
    input  logic [SW-1:0] dp_req_size,
    input  logic [DW-1:0] dp_req_wdata,
    input  logic          dp_req_fetch,
    output logic          dp_req_acc,
    output logic          dp_retry_req,
    output logic          dp_rsp_vld,
    output logic [AW-1:0] dp_rsp_addr,
    output logic          dp_rsp_wr,
    output logic [DW-1:0] dp_rsp_rdata,
    input  logic          dp_rsp_acc,
    input  logic          dp_rsp_retry,
    output logic          mem_req_vld,
    output logic [AW-1:0] mem_req_addr,
    output logic          mem_req_wr,
    output logic [SW-1:0] mem_req_size,
    output logic [DW-1:0] mem_req_wdata,
    output logic          mem_req_fetch,
    input  logic          mem_req_acc,
    input  logic          mem_retry,
    input  logic          mem_rsp_vld,
    input  logic [DW-1:0] mem_rsp_rdata
);
    localparam int AO = DW;
    localparam int SO = DW + AW;
    localparam int WO = DW + AW + SW;
    localparam int FO = WO + 1;
    localparam int PW = FO + 1;

    logic [PW-1:0]    ip_pkt, dp_pkt, take_pkt, pkt_q;
    logic             path_idle, rsp_take, can_take, take;
    logic [NPORT-1:0] refused, load, holding, retry, rsp_vld, rsp_acc, rsp_retry, rsp_wr;
    logic [AW-1:0]    rsp_addr [NPORT];
    logic [DW-1:0]    rsp_data [NPORT];

    assign ip_pkt = {ip_req_fetch, ip_req_wr, ip_req_size, ip_req_addr, ip_req_wdata};
    assign dp_pkt = {dp_req_fetch, dp_req_wr, dp_req_size, dp_req_addr, dp_req_wdata};

    assign can_take   = path_idle && (holding == '0);
    assign ip_req_acc = ip_req_vld && can_take;
    assign dp_req_acc = dp_req_vld && can_take && !ip_req_vld;
    assign take       = ip_req_acc || dp_req_acc;
    assign take_pkt   = ip_req_acc ? ip_pkt : dp_pkt;

    assign refused[PORT_I] = ip_req_vld && !ip_req_acc;
    assign refused[PORT_D] = dp_req_vld && !dp_req_acc;
    assign load[PORT_I]    = rsp_take && pkt_q[FO];
    assign load[PORT_D]    = rsp_take && !pkt_q[FO];

    assign rsp_acc   = {dp_rsp_acc, ip_rsp_acc};
    assign rsp_retry = {dp_rsp_retry, ip_rsp_retry};

    fwd_req_path #(.PW(PW)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .take_pkt   (take_pkt),
        .mem_acc    (mem_req_acc),
        .mem_retry  (mem_retry),
        .mem_rsp_vld(mem_rsp_vld),
        .pkt_q      (pkt_q),
        .mem_vld    (mem_req_vld),
        .idle       (path_idle),
        .rsp_take   (rsp_take)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fwd_port_side #(.AW(AW), .DW(DW)) u_side (
            .clk      (clk),
            .rst_n    (rst_n),
            .refused  (refused[p]),
            .retry_ok (can_take && !take),
            .load     (load[p]),
            .load_addr(pkt_q[AO +: AW]),
            .load_wr  (pkt_q[WO]),
            .load_data(mem_rsp_rdata),
            .rsp_acc  (rsp_acc[p]),
            .rsp_retry(rsp_retry[p]),
            .retry_req(retry[p]),
            .rsp_vld  (rsp_vld[p]),
            .rsp_addr (rsp_addr[p]),
            .rsp_wr   (rsp_wr[p]),
            .rsp_data (rsp_data[p]),
            .holding  (holding[p])
        );
    end

    assign mem_req_wdata = pkt_q[DW-1:0];
    assign mem_req_addr  = pkt_q[AO +: AW];
    assign mem_req_size  = pkt_q[SO +: SW];
    assign mem_req_wr    = pkt_q[WO];
    assign mem_req_fetch = pkt_q[FO];

    assign ip_retry_req = retry[PORT_I];
    assign ip_rsp_vld   = rsp_vld[PORT_I];
    assign ip_rsp_addr  = rsp_addr[PORT_I];
    assign ip_rsp_wr    = rsp_wr[PORT_I];
    assign ip_rsp_rdata = rsp_data[PORT_I];
    assign dp_retry_req = retry[PORT_D];
    assign dp_rsp_vld   = rsp_vld[PORT_D];
    assign dp_rsp_addr  = rsp_addr[PORT_D];
    assign dp_rsp_wr    = rsp_wr[PORT_D];
    assign dp_rsp_rdata = rsp_data[PORT_D];

    AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(holding)); // R1
    AST_INST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req_acc |-> !ip_req_vld); // R10
    AST_NO_MEM_WHILE_HOLDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_vld |-> (holding == '0)); // R1
endmodule

// File: tb/fwd_dual_blocking_tb.sv
module fwd_dual_blocking_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = 2;
    localparam int NCYC = 6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic ip_req_vld = 0, ip_req_wr = 0, ip_req_fetch = 0, ip_rsp_acc = 0, ip_rsp_retry = 0;
    logic [AW-1:0] ip_req_addr = '0;
    logic [SW-1:0] ip_req_size = '0;
    logic [DW-1:0] ip_req_wdata = '0;
    logic dp_req_vld = 0, dp_req_wr = 0, dp_req_fetch = 0, dp_rsp_acc = 0, dp_rsp_retry = 0;
    logic [AW-1:0] dp_req_addr = '0;
    logic [SW-1:0] dp_req_size = '0;
    logic [DW-1:0] dp_req_wdata = '0;
    logic mem_req_acc = 0, mem_retry = 0, mem_rsp_vld = 0;
    logic [DW-1:0] mem_rsp_rdata = '0;

    logic ip_req_acc, ip_retry_req, ip_rsp_vld, ip_rsp_wr;
    logic [AW-1:0] ip_rsp_addr;
    logic [DW-1:0] ip_rsp_rdata;
    logic dp_req_acc, dp_retry_req, dp_rsp_vld, dp_rsp_wr;
    logic [AW-1:0] dp_rsp_addr;
    logic [DW-1:0] dp_rsp_rdata;
    logic mem_req_vld, mem_req_wr, mem_req_fetch;
    logic [AW-1:0] mem_req_addr;
    logic [SW-1:0] mem_req_size;
    logic [DW-1:0] mem_req_wdata;

    fwd_dual_blocking #(.AW(AW), .DW(DW), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ip_req_vld(ip_req_vld), .ip_req_addr(ip_req_addr), .ip_req_wr(ip_req_wr),
        .ip_req_size(ip_req_size), .ip_req_wdata(ip_req_wdata), .ip_req_fetch(ip_req_fetch),
        .ip_req_acc(ip_req_acc), .ip_retry_req(ip_retry_req), .ip_rsp_vld(ip_rsp_vld),
        .ip_rsp_addr(ip_rsp_addr), .ip_rsp_wr(ip_rsp_wr), .ip_rsp_rdata(ip_rsp_rdata),
        .ip_rsp_acc(ip_rsp_acc), .ip_rsp_retry(ip_rsp_retry),
        .dp_req_vld(dp_req_vld), .dp_req_addr(dp_req_addr), .dp_req_wr(dp_req_wr),
        .dp_req_size(dp_req_size), .dp_req_wdata(dp_req_wdata), .dp_req_fetch(dp_req_fetch),
        .dp_req_acc(dp_req_acc), .dp_retry_req(dp_retry_req), .dp_rsp_vld(dp_rsp_vld),
        .dp_rsp_addr(dp_rsp_addr), .dp_rsp_wr(dp_rsp_wr), .dp_rsp_rdata(dp_rsp_rdata),
        .dp_rsp_acc(dp_rsp_acc), .dp_rsp_retry(dp_rsp_retry),
        .mem_req_vld(mem_req_vld), .mem_req_addr(mem_req_addr), .mem_req_wr(mem_req_wr),
        .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata), .mem_req_fetch(mem_req_fetch),
        .mem_req_acc(mem_req_acc), .mem_retry(mem_retry), .mem_rsp_vld(mem_rsp_vld),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input int n);
        return int'($urandom % n);
    endfunction

    // reference state, derived from the requirements
    int mst;            // 0 idle, 1 send, 2 held, 3 wait
    int wait_cnt;
    logic [AW-1:0] p_addr; logic p_wr; logic [SW-1:0] p_size; logic [DW-1:0] p_wdata; logic p_fetch;
    int hst [2];        // 0 empty, 1 send, 2 held
    bit h_again [2];
    logic [AW-1:0] h_addr [2]; logic h_wr [2]; logic [DW-1:0] h_data [2];
    bit need [2];

    task automatic step(input int phase, input bit both);
        bit can, e_iacc, e_dacc, any;
        bit e_retry [2];
        logic [AW-1:0] oaddr [2]; logic owr [2]; logic [DW-1:0] odata [2];
        logic ovld [2], oacc [2], oretry [2], racc [2], rretry [2];
        int tgt;
        @(negedge clk);
        // drive
        ip_req_vld   = both ? 1'b1 : (!need[0] && rnd(3) == 0);
        dp_req_vld   = both ? 1'b1 : (!need[1] && rnd(3) == 0);
        ip_req_addr  = AW'($urandom); ip_req_wr = 1'($urandom); ip_req_size = SW'($urandom);
        ip_req_wdata = $urandom; ip_req_fetch = (rnd(8) != 0);
        dp_req_addr  = AW'($urandom); dp_req_wr = 1'($urandom); dp_req_size = SW'($urandom);
        dp_req_wdata = $urandom; dp_req_fetch = (rnd(8) == 0);
        mem_req_acc  = (phase == 0) ? 1'b1 : (rnd(2) == 0);
        mem_retry    = (mst == 2) && (rnd(3) == 0);
        mem_rsp_vld  = (mst == 3) && (wait_cnt == 0);
        mem_rsp_rdata = $urandom;
        ip_rsp_acc   = (phase == 0) ? 1'b1 : (rnd(2) == 0);
        dp_rsp_acc   = (phase == 0) ? 1'b1 : (rnd(2) == 0);
        ip_rsp_retry = (hst[0] == 2) && (rnd(3) == 0);
        dp_rsp_retry = (hst[1] == 2) && (rnd(3) == 0);
        #1;
        // expected outputs
        can    = (mst == 0) && (hst[0] == 0) && (hst[1] == 0);
        e_iacc = ip_req_vld && can;
        e_dacc = dp_req_vld && can && !ip_req_vld;
        any    = e_iacc || e_dacc;
        for (int p = 0; p < 2; p++) e_retry[p] = need[p] && can && !any;
        oacc[0] = ip_req_acc; oacc[1] = dp_req_acc;
        oretry[0] = ip_retry_req; oretry[1] = dp_retry_req;
        ovld[0] = ip_rsp_vld; ovld[1] = dp_rsp_vld;
        oaddr[0] = ip_rsp_addr; oaddr[1] = dp_rsp_addr;
        owr[0] = ip_rsp_wr; owr[1] = dp_rsp_wr;
        odata[0] = ip_rsp_rdata; odata[1] = dp_rsp_rdata;
        racc[0] = ip_rsp_acc; racc[1] = dp_rsp_acc;
        rretry[0] = ip_rsp_retry; rretry[1] = dp_rsp_retry;

        chk(ip_req_acc == e_iacc, e_iacc ? "R6" : "R1", "ip_req_acc", 64'(ip_req_acc), 64'(e_iacc));
        chk(dp_req_acc == e_dacc, (ip_req_vld && dp_req_vld) ? "R10" : "R1", "dp_req_acc",
            64'(dp_req_acc), 64'(e_dacc));
        for (int p = 0; p < 2; p++)
            chk(oretry[p] == e_retry[p], e_retry[p] ? "R2" : "R7", "retry_req",
                64'(oretry[p]), 64'(e_retry[p]));
        chk(mem_req_vld == (mst == 1), (mst == 2) ? "R4" : "R3", "mem_req_vld",
            64'(mem_req_vld), 64'(mst == 1));
        if (mst == 1) begin
            chk(mem_req_addr == p_addr, "R3", "mem_req_addr", 64'(mem_req_addr), 64'(p_addr));
            chk(mem_req_wdata == p_wdata, "R3", "mem_req_wdata", 64'(mem_req_wdata), 64'(p_wdata));
            chk({mem_req_fetch, mem_req_wr, mem_req_size} == {p_fetch, p_wr, p_size}, "R3",
                "mem_req_ctl", 64'({mem_req_fetch, mem_req_wr, mem_req_size}),
                64'({p_fetch, p_wr, p_size}));
        end
        for (int p = 0; p < 2; p++) begin
            chk(ovld[p] == (hst[p] == 1), (hst[p] == 2) ? "R8" : "R5", "rsp_vld",
                64'(ovld[p]), 64'(hst[p] == 1));
            if (hst[p] == 1) begin
                chk(oaddr[p] == h_addr[p] && owr[p] == h_wr[p], h_again[p] ? "R8" : "R5",
                    "rsp_addr_wr", 64'({owr[p], oaddr[p]}), 64'({h_wr[p], h_addr[p]}));
                chk(odata[p] == h_data[p], h_again[p] ? "R8" : "R5", "rsp_rdata",
                    64'(odata[p]), 64'(h_data[p]));
            end
        end
        // update reference
        for (int p = 0; p < 2; p++) begin
            if (hst[p] == 1) hst[p] = racc[p] ? 0 : 2;
            else if (hst[p] == 2 && rretry[p]) begin hst[p] = 1; h_again[p] = 1'b1; end
        end
        case (mst)
            0: if (any) begin
                mst = 1;
                if (e_iacc) begin
                    p_addr = ip_req_addr; p_wr = ip_req_wr; p_size = ip_req_size;
                    p_wdata = ip_req_wdata; p_fetch = ip_req_fetch;
                end else begin
                    p_addr = dp_req_addr; p_wr = dp_req_wr; p_size = dp_req_size;
                    p_wdata = dp_req_wdata; p_fetch = dp_req_fetch;
                end
            end
            1: if (mem_req_acc) begin mst = 3; wait_cnt = rnd(3); end else mst = 2;
            2: if (mem_retry) mst = 1;
            default: if (mem_rsp_vld) begin
                mst = 0;
                tgt = p_fetch ? 0 : 1;
                hst[tgt] = 1; h_again[tgt] = 1'b0;
                h_addr[tgt] = p_addr; h_wr[tgt] = p_wr; h_data[tgt] = mem_rsp_rdata;
            end else wait_cnt--;
        endcase
        if (ip_req_vld && !e_iacc) need[0] = 1'b1; else if (e_retry[0]) need[0] = 1'b0;
        if (dp_req_vld && !e_dacc) need[1] = 1'b1; else if (e_retry[1]) need[1] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        mst = 0; wait_cnt = 0;
        p_addr = '0; p_wr = 0; p_size = '0; p_wdata = '0; p_fetch = 0;
        for (int p = 0; p < 2; p++) begin
            hst[p] = 0; need[p] = 0; h_again[p] = 0;
            h_addr[p] = '0; h_wr[p] = 0; h_data[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state visible at the ports
        chk(!mem_req_vld && !ip_rsp_vld && !dp_rsp_vld, "R9", "valids_in_reset",
            64'({mem_req_vld, ip_rsp_vld, dp_rsp_vld}), 64'd0);
        chk(!ip_retry_req && !dp_retry_req && !ip_req_acc && !dp_req_acc, "R9", "acc_retry_in_reset",
            64'({ip_retry_req, dp_retry_req, ip_req_acc, dp_req_acc}), 64'd0);
        rst_n = 1'b1;
        // R10 directed: both requesters at once on an idle block
        step(0, 1'b1);
        for (int c = 0; c < 40; c++) step(0, 1'b0);
        step(1, 1'b1);
        for (int c = 0; c < NCYC; c++) step((c / 1500) % 2 == 0 ? 1 : ((c % 500) < 100 ? 0 : 1), 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule